// File: doc/BRIEF.md
# Time-Multiplexed FIR Filter with Ready Throttling

This block is a finite impulse response filter that handles one sample at a time. It reuses a small bank of multiply-accumulate units over several clock cycles for each sample instead of building one multiplier per tap. A parameter `CYCLES` sets the minimum spacing between accepted samples. The number of multiply-accumulate units is the number of folded taps divided by `CYCLES`, rounded up. Each unit steps through its share of coefficients with a shared step counter, and the unit totals are summed once the last step is done.

The upstream side offers a sample with `validIn` and watches `ready`. A sample is taken only in a cycle where both are high. Offers made while `ready` is low are dropped. When the coefficients mirror around the centre (`FOLD` = 1 for even symmetry, 2 for odd symmetry), each pair of mirrored taps goes through one pre-adder or pre-subtractor before it reaches a shared multiplier, which halves the multiplications per sample. The asynchronous reset `rst_n` clears only the sequencing state. An optional synchronous input `syncClr` (enabled by `DP_CLR_EN`) clears the sample history, the accumulators and the output data register.

Top module: `tdm_fir`

## Requirements
- R1: `ready` is high while no sample is being processed. After a sample is accepted, `ready` is low for exactly `CYCLES`-1 cycles and then high again.
- R2: A `validIn` pulse that arrives while `ready` is low has no effect. The sample is not stored, and later outputs are computed as if it had never been offered.
- R3: Each output is y = sum over i of c[i]*x[n-i], for i = 0 to `TAPS`-1. Here x[n] is the newest accepted sample, x[n-i] is the sample accepted i acceptances earlier, and c[i] is the signed `COEF_W`-bit field at bit offset i*`COEF_W` of `COEFS`. Data and coefficients are two's complement. `dataOut` is the full-precision signed sum, `DATA_W`+`COEF_W`+clog2(`TAPS`)+1 bits wide.
- R4: Suppose a sample is accepted at clock edge k. Then `validOut` is high during the cycle after edge k+`CYCLES`+1, and `dataOut` holds that sample's result in that same cycle.
- R5: `validOut` is high for exactly one cycle per accepted sample and never rises without an accepted sample.
- R6: With `FOLD` = 1, the filter uses only c[0] to c[ceil(`TAPS`/2)-1] and behaves as if c[`TAPS`-1-i] = c[i].
- R7: With `FOLD` = 2, the filter behaves as if c[`TAPS`-1-i] = -c[i], and as if the middle coefficient of an odd-length filter were the value stored for it (zero in a true odd-symmetric filter).
- R8: `dataOut` keeps its value between `validOut` pulses.
- R9: With `DP_CLR_EN` = 1, `syncClr` high at an edge sets `dataOut` to 0 and empties the sample history. Later outputs treat every earlier sample as zero. It does not change `ready` or `validOut`.
- R10: While `rst_n` is low, `ready` is 1 and `validOut` is 0.
- R11: When `validIn` is held high, a new sample is accepted in the same cycle as the previous sample's last serial step, so samples are taken every `CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencing state |
| syncClr | input | 1 | Synchronous clear of the sample history, accumulators and output data |
| dataIn | input | DATA_W | Signed input sample |
| validIn | input | 1 | Input sample offered |
| ready | output | 1 | The sample offered in this cycle will be accepted |
| dataOut | output | DATA_W+COEF_W+clog2(TAPS)+1 | Signed filter output |
| validOut | output | 1 | One-cycle strobe marking a new `dataOut` |

## Verification
A step counter that skips or repeats a value makes some multiply-accumulate unit drop or double one coefficient slot. An impulse shows this in the first output after it, `CYCLES`+1 edges after acceptance. A pairing or sign mistake in the folding shows up as wrong mirrored coefficients in the same impulse readout. A delay line that shifts on a dropped offer shows up in the max-rate phase as a wrong result within `TAPS` outputs. Sequencing faults are visible within one sample period: `ready` is checked every cycle against its expected pattern, and `validOut` is checked against the cycle predicted from each acceptance.

// File: rtl/tdm_fir_pkg.sv
package tdm_fir_pkg;

  // Strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic load;   // accepted sample: shift the history
    logic macEn;  // a serial step is active
    logic first;  // step 0: restart accumulation
    logic sumEn;  // all steps done: capture the unit total
  } strobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/tdm_fir_ctrl.sv
module tdm_fir_ctrl
  import tdm_fir_pkg::*;
#(
  parameter int CYCLES = 3,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              validIn,
  output logic              ready,
  output logic              validOut,
  output strobe_t           str,
  output logic [STEP_W-1:0] step
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(CYCLES - 1);

  logic busy;
  logic doneQ;
  logic accept;
  logic lastStep;

  assign lastStep = busy && (step == LAST);
  // The next sample may enter in the cycle of the last serial step
  assign ready    = !busy || (step == LAST);
  assign accept   = validIn && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      step     <= '0;
      doneQ    <= 1'b0;
      validOut <= 1'b0;
    end else begin
      doneQ    <= lastStep;
      validOut <= doneQ;
      if (accept) begin
        busy <= 1'b1;
        step <= '0;
      end else if (lastStep) begin
        busy <= 1'b0;
      end else if (busy) begin
        step <= step + 1'b1;
      end
    end
  end

  assign str.load  = accept;
  assign str.macEn = busy;
  assign str.first = busy && (step == '0);
  assign str.sumEn = doneQ;

  generate
    if (CYCLES > 1) begin : g_pace
      // R1
      ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready);
      // R5
      valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        validOut |=> !validOut);
    end
  endgenerate

  // R11
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step <= LAST));

endmodule

// File: rtl/tdm_fir_mac.sv
module tdm_fir_mac #(
  parameter int CYCLES = 3,
  parameter int STEP_W = 2,
  parameter int OPW    = 9,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 20
) (
  input  logic                           clk,
  input  logic                           clr,
  input  logic                           macEn,
  input  logic                           first,
  input  logic [STEP_W-1:0]              step,
  input  logic [CYCLES-1:0][OPW-1:0]    opnds,
  input  logic [CYCLES-1:0][COEF_W-1:0] coefs,
  output logic [ACC_W-1:0]               acc
);

  localparam int PROD_W = OPW + COEF_W;

  logic [OPW-1:0]           opSel;
  logic [COEF_W-1:0]        cfSel;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         prodExt;

  always_comb begin
    opSel = '0;
    cfSel = '0;
    for (int k = 0; k < CYCLES; k++) begin
      if (step == STEP_W'(k)) begin
        opSel = opnds[k];
        cfSel = coefs[k];
      end
    end
  end

  assign prod    = $signed(opSel) * $signed(cfSel);
  assign prodExt = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (clr)        acc <= '0;
    else if (macEn) acc <= first ? prodExt : acc + prodExt;
  end

endmodule

// File: rtl/tdm_fir_dpath.sv
module tdm_fir_dpath
  import tdm_fir_pkg::*;
#(
  parameter int                     DATA_W    = 8,
  parameter int                     COEF_W    = 8,
  parameter int                     TAPS      = 8,
  parameter int                     CYCLES    = 3,
  parameter int                     FOLD      = 1,
  parameter bit                     DP_CLR_EN = 1'b1,
  parameter logic [TAPS*COEF_W-1:0] COEFS     = '0,
  parameter int                     STEP_W    = 2,
  parameter int                     OUT_W     = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              syncClr,
  input  strobe_t           str,
  input  logic [STEP_W-1:0] step,
  input  logic [DATA_W-1:0] dataIn,
  output logic [OUT_W-1:0]  dataOut
);

  localparam int FOLDED = (FOLD == 0) ? TAPS : (TAPS + 1) / 2;
  localparam int UNITS  = ceilDiv(FOLDED, CYCLES);
  localparam int OPW    = DATA_W + 1;

  logic                                       clrEff;
  logic [TAPS-1:0][DATA_W-1:0]                line;
  logic [FOLDED-1:0][OPW-1:0]                 fold;
  logic [UNITS-1:0][CYCLES-1:0][OPW-1:0]      opnds;
  logic [UNITS-1:0][CYCLES-1:0][COEF_W-1:0]   coefs;
  logic [UNITS-1:0][OUT_W-1:0]                accs;
  logic [OUT_W-1:0]                           total;

  generate
    if (DP_CLR_EN) begin : g_clr
      assign clrEff = syncClr;
    end else begin : g_noclr
      assign clrEff = 1'b0;
    end
  endgenerate

  // Sample history: index 0 is the newest accepted sample
  always_ff @(posedge clk) begin
    if (clrEff)        line <= '0;
    else if (str.load) line <= {line[TAPS-2:0], dataIn};
  end

  // Pre-add (or pre-subtract) mirrored taps
  generate
    for (genvar f = 0; f < FOLDED; f++) begin : g_fold
      if (FOLD == 0 || 2 * f == TAPS - 1) begin : g_single
        assign fold[f] = {line[f][DATA_W-1], line[f]};
      end else if (FOLD == 1) begin : g_sym
        assign fold[f] = {line[f][DATA_W-1], line[f]}
                       + {line[TAPS-1-f][DATA_W-1], line[TAPS-1-f]};
      end else begin : g_anti
        assign fold[f] = {line[f][DATA_W-1], line[f]}
                       - {line[TAPS-1-f][DATA_W-1], line[TAPS-1-f]};
      end
    end
  endgenerate

  // Unit u owns folded taps u*CYCLES .. u*CYCLES+CYCLES-1; slots past the end are zero
  generate
    for (genvar u = 0; u < UNITS; u++) begin : g_unit
      for (genvar k = 0; k < CYCLES; k++) begin : g_slot
        localparam int IDX = u * CYCLES + k;
        if (IDX < FOLDED) begin : g_live
          assign opnds[u][k] = fold[IDX];
          assign coefs[u][k] = COEFS[IDX*COEF_W +: COEF_W];
        end else begin : g_pad
          assign opnds[u][k] = '0;
          assign coefs[u][k] = '0;
        end
      end

      tdm_fir_mac #(
        .CYCLES (CYCLES),
        .STEP_W (STEP_W),
        .OPW    (OPW),
        .COEF_W (COEF_W),
        .ACC_W  (OUT_W)
      ) mac_i (
        .clk   (clk),
        .clr   (clrEff),
        .macEn (str.macEn),
        .first (str.first),
        .step  (step),
        .opnds (opnds[u]),
        .coefs (coefs[u]),
        .acc   (accs[u])
      );
    end
  endgenerate

  always_comb begin
    total = '0;
    for (int u = 0; u < UNITS; u++) total = total + accs[u];
  end

  always_ff @(posedge clk) begin
    if (clrEff)         dataOut <= '0;
    else if (str.sumEn) dataOut <= total;
  end

  // R2
  hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!str.load && !clrEff) |=> $stable(line));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!str.sumEn && !clrEff) |=> $stable(dataOut));

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clrEff |=> (dataOut == '0));

endmodule

// File: rtl/tdm_fir.sv
module tdm_fir
  import tdm_fir_pkg::*;
#(
  parameter int                     DATA_W    = 8,
  parameter int                     COEF_W    = 8,
  parameter int                     TAPS      = 8,
  parameter int                     CYCLES    = 3,
  parameter int                     FOLD      = 1,
  parameter bit                     DP_CLR_EN = 1'b1,
  parameter logic [TAPS*COEF_W-1:0] COEFS     =
    {8'h03, 8'hFB, 8'h0C, 8'h1B, 8'h1B, 8'h0C, 8'hFB, 8'h03}
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   syncClr,
  input  logic [DATA_W-1:0]                      dataIn,
  input  logic                                   validIn,
  output logic                                   ready,
  output logic [DATA_W+COEF_W+$clog2(TAPS):0]    dataOut,
  output logic                                   validOut
);

  localparam int STEP_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam int OUT_W  = DATA_W + COEF_W + $clog2(TAPS) + 1;

  strobe_t           str;
  logic [STEP_W-1:0] step;

  tdm_fir_ctrl #(
    .CYCLES (CYCLES),
    .STEP_W (STEP_W)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .validIn  (validIn),
    .ready    (ready),
    .validOut (validOut),
    .str      (str),
    .step     (step)
  );

  tdm_fir_dpath #(
    .DATA_W    (DATA_W),
    .COEF_W    (COEF_W),
    .TAPS      (TAPS),
    .CYCLES    (CYCLES),
    .FOLD      (FOLD),
    .DP_CLR_EN (DP_CLR_EN),
    .COEFS     (COEFS),
    .STEP_W    (STEP_W),
    .OUT_W     (OUT_W)
  ) dpath_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .syncClr (syncClr),
    .str     (str),
    .step    (step),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: tb/tdm_fir_tb_top.sv
module tdm_fir_tb_top;

  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        syncClr = 1'b0;
  logic        validIn = 1'b0;
  logic [7:0]  dataIn = '0;
  logic        readyA, readyB, validA, validB;
  logic [19:0] dataA, dataB;

  always #10 clk = ~clk;

  tdm_fir #(.CYCLES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .syncClr(syncClr), .dataIn(dataIn),
    .validIn(validIn), .ready(readyA), .dataOut(dataA), .validOut(validA)
  );

  tdm_fir #(
    .TAPS(7), .CYCLES(N), .FOLD(2),
    .COEFS({8'hFC, 8'h09, 8'hEC, 8'h00, 8'h14, 8'hF7, 8'h04})
  ) dutAnti_i (
    .clk(clk), .rst_n(rst_n), .syncClr(syncClr), .dataIn(dataIn),
    .validIn(validIn), .ready(readyB), .dataOut(dataB), .validOut(validB)
  );

  int cA[8] = '{3, -5, 12, 27, 27, 12, -5, 3};
  int cB[7] = '{4, -9, 20, 0, -20, 9, -4};
  int hA[8];
  int hB[7];
  bit expV[16];
  int expA[16];
  int expB[16];
  int lastA, lastB;
  int cnt, tcyc, checks, fails;
  bit clrPrev;
  int lfsr = 32'h1ACE;
  string phaseTag = "init";

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] actual %0d expected %0d", what, phaseTag, act, exp);
    end
  endtask

  function automatic int nextRand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >>> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // One clock cycle: check outputs, update model, drive inputs
  task automatic cycle(input bit vin, input int din, input bit clr);
    int slot, sa, sb, nd;
    bit acc;
    @(negedge clk);
    slot = tcyc % 16;
    chk(readyA == (cnt == 0), "R1/R11 ready A", int'(readyA), int'(cnt == 0));
    chk(readyB == (cnt == 0), "R1/R11 ready B", int'(readyB), int'(cnt == 0));
    chk(validA == expV[slot], "R4/R5 validOut A", int'(validA), int'(expV[slot]));
    chk(validB == expV[slot], "R4/R5 validOut B", int'(validB), int'(expV[slot]));
    if (expV[slot]) begin
      lastA = expA[slot];
      lastB = expB[slot];
    end
    if (clrPrev) begin
      chk(int'($signed(dataA)) == 0, "R9 cleared dataOut A", int'($signed(dataA)), 0);
      chk(int'($signed(dataB)) == 0, "R9 cleared dataOut B", int'($signed(dataB)), 0);
    end else if (expV[slot]) begin
      chk(int'($signed(dataA)) == lastA, "R2/R3/R6 dataOut A", int'($signed(dataA)), lastA);
      chk(int'($signed(dataB)) == lastB, "R2/R3/R7 dataOut B", int'($signed(dataB)), lastB);
    end else begin
      chk(int'($signed(dataA)) == lastA, "R8 held dataOut A", int'($signed(dataA)), lastA);
      chk(int'($signed(dataB)) == lastB, "R8 held dataOut B", int'($signed(dataB)), lastB);
    end
    expV[slot] = 1'b0;
    clrPrev = clr;

    acc = vin && (cnt == 0);
    nd  = int'($signed(8'(din)));
    if (acc) begin
      for (int i = 7; i > 0; i--) hA[i] = hA[i-1];
      for (int i = 6; i > 0; i--) hB[i] = hB[i-1];
      hA[0] = nd;
      hB[0] = nd;
      sa = 0;
      sb = 0;
      for (int i = 0; i < 8; i++) sa += cA[i] * hA[i];
      for (int i = 0; i < 7; i++) sb += cB[i] * hB[i];
      expV[(tcyc + N + 2) % 16] = 1'b1;
      expA[(tcyc + N + 2) % 16] = sa;
      expB[(tcyc + N + 2) % 16] = sb;
      cnt = N - 1;
    end else if (cnt > 0) begin
      cnt--;
    end
    if (clr) begin
      for (int i = 0; i < 8; i++) hA[i] = 0;
      for (int i = 0; i < 7; i++) hB[i] = 0;
      lastA = 0;
      lastB = 0;
    end
    validIn = vin;
    dataIn  = 8'(din);
    syncClr = clr;
    tcyc++;
  endtask

  task automatic send(input int din);
    while (cnt != 0) cycle(1'b0, 0, 1'b0);
    cycle(1'b1, din, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 0, 1'b0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R10: reset state
    phaseTag = "R10 reset";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(readyA && readyB, "R10 ready in reset", int'(readyA && readyB), 1);
      chk(!validA && !validB, "R10 validOut in reset", int'(validA || validB), 0);
    end
    rst_n = 1'b1;

    // R9: clear the data path before use
    phaseTag = "R9 initial clear";
    cycle(1'b0, 0, 1'b1);
    idle(3);

    // R3/R6/R7: impulse responses read the coefficients back
    phaseTag = "R3 impulse";
    send(1);
    for (int i = 0; i < 9; i++) send(0);
    send(127);
    for (int i = 0; i < 9; i++) send(0);
    idle(N + 3);

    // R2/R11: validIn held high, offers while not ready are dropped
    phaseTag = "R2/R11 max rate";
    for (int i = 0; i < 600; i++) cycle(1'b1, nextRand() & 255, 1'b0);
    idle(N + 3);

    // R5: sparse random offers
    phaseTag = "R5 random";
    for (int i = 0; i < 3000; i++) cycle(1'((nextRand() >> 4) & 1), nextRand() & 255, 1'b0);
    idle(N + 3);

    // R3: extremes
    phaseTag = "R3 extremes";
    for (int i = 0; i < 20; i++) send(-128);
    for (int i = 0; i < 20; i++) send((i % 2) ? 127 : -128);
    for (int i = 0; i < 20; i++) send(127);
    idle(N + 3);

    // R9: clear mid-stream while idle, history restarts at zero
    phaseTag = "R9 clear";
    cycle(1'b0, 0, 1'b1);
    idle(2);
    for (int i = 0; i < 12; i++) send(nextRand() & 255);
    idle(N + 3);

    // R3: sweep every input code
    phaseTag = "R3 sweep";
    for (int v = 0; v < 256; v++) send(v);
    for (int v = 0; v < 256; v++) send(255 - v);
    idle(N + 4);

    finishRun();
  end

endmodule